// File: doc/BRIEF.md
# Host word-to-byte transmit packer

The packer sits between a host's 32-bit data writes and a byte-wide packet queue. A setup write programs how the next words are to be cut up. That setup sets the byte order, how many leading bytes to drop from the first word, how many trailing bytes to drop from the last word, and the number of data writes in the buffer minus one. Each accepted data word is reordered into transmit order and trimmed. The bytes that survive are sent one per cycle on a valid/ready byte stream.

The write count counts down on every data write. A non-zero count means more words follow. A zero count marks the final word, and every later word is treated the same way until a new setup write. The leading trim is used once and then clears itself. The trailing trim stays in force.

A packet length is sampled with the setup write, and the block tracks how many packet bytes are still to be sent. When fewer than four remain, that remainder sets the number of bytes kept, in place of the trailing trim. The host may offer a new word only while the four-byte holding buffer is empty.

Top module: `word_byte_packer`

## Requirements
- R1: A setup write (`cfg_we`) decodes `cfg_wdata` as follows: bit 24 is the byte order, bits 19:18 are the leading trim, bits 17:16 are the trailing trim, and bits 13:0 are the write count. All other bits have no effect on the output.
- R2: With bit 24 set, bytes leave most significant first (`wr_data[31:24]` first). With bit 24 clear, they leave least significant first (`wr_data[7:0]` first).
- R3: While the count is non-zero, a data write drops as many leading bytes, in transmit order, as the leading trim says. The trim then becomes zero, so later words are not cut at the front.
- R4: The count falls by one on each data write while it is non-zero. It then stays at zero until the next setup write.
- R5: Each data write made while the count is zero drops as many trailing bytes as the trailing trim says. The trim is not cleared, so it applies to every later such write.
- R6: A remaining-byte counter is loaded from `pkt_len` at the setup write and falls by the number of bytes kept on each data write. If it is below 4 when a word is accepted, the number of bytes kept is the smaller of that remainder and the bytes left after the leading trim, and the trailing trim is ignored.
- R7: `wr_ready` is high only while the holding buffer is empty. Kept bytes appear on `out_byte` one per handshake cycle, in transmit order. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_byte` hold.
- R8: A word that keeps no bytes is accepted, produces no `out_valid`, and leaves `wr_ready` high.
- R9: A synchronous reset clears the setup state to all zeros (including the remaining-byte counter) and empties the holding buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Setup write strobe |
| cfg_wdata | input | 32 | Setup word |
| pkt_len | input | SIZE_W | Packet length in bytes, sampled at setup write |
| wr_valid | input | 1 | Host data word valid |
| wr_ready | output | 1 | Holding buffer empty, word may be accepted |
| wr_data | input | 32 | Host data word |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Queue accepts the output byte |
| out_byte | output | 8 | Output byte |

## Verification
The bench builds the packer with `SIZE_W` = 8. This keeps packet lengths small enough that the remainder override can be driven to every value from 0 to 3, next to a length that never triggers it. With that setting the bench sweeps both byte orders, every leading and trailing trim, and counts 0 to 2, with two extra words past the count. This brings the self-clearing front trim, the persistent back trim and the held zero count into every combination with each remainder. Half the setup words carry ones in every reserved bit, and one byte in two is held back under backpressure.

// File: rtl/word_byte_packer.sv
module word_byte_packer #(
  parameter int SIZE_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic [SIZE_W-1:0] pkt_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [31:0]       wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte
);
  localparam int CNT_W = 14;

  logic              msb_first;
  logic [1:0]        st_off, end_off;
  logic [CNT_W-1:0]  wcount;
  logic [SIZE_W-1:0] rem;
  logic [31:0]       hold;
  logic [1:0]        ptr;
  logic [2:0]        left;

  logic [31:0] ord;
  logic [2:0]  lead, avail, keep;
  logic        wr_fire, rem_small;

  for (genvar i = 0; i < 4; i++) begin : g_ord
    assign ord[8*i +: 8] = msb_first ? wr_data[31-8*i -: 8] : wr_data[8*i +: 8];
  end

  assign wr_fire   = wr_valid && wr_ready;
  assign lead      = (wcount != '0) ? {1'b0, st_off} : 3'd0;
  assign avail     = 3'd4 - lead;
  assign rem_small = rem < SIZE_W'(4);

  always_comb begin
    if (rem_small)
      keep = (rem[2:0] < avail) ? rem[2:0] : avail;
    else if (wcount == '0)
      keep = ({1'b0, end_off} >= avail) ? 3'd0 : avail - {1'b0, end_off};
    else
      keep = avail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_first <= 1'b0;
      st_off    <= '0;
      end_off   <= '0;
      wcount    <= '0;
      rem       <= '0;
    end else if (cfg_we) begin
      msb_first <= cfg_wdata[24];
      st_off    <= cfg_wdata[19:18];
      end_off   <= cfg_wdata[17:16];
      wcount    <= cfg_wdata[13:0];
      rem       <= pkt_len;
    end else if (wr_fire) begin
      if (wcount != '0) begin
        wcount <= wcount - CNT_W'(1);
        st_off <= '0;
      end
      rem <= rem - SIZE_W'(keep);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      ptr  <= '0;
      left <= '0;
    end else if (wr_fire) begin
      hold <= ord;
      ptr  <= lead[1:0];
      left <= keep;
    end else if (out_valid && out_ready) begin
      ptr  <= ptr + 2'd1;
      left <= left - 3'd1;
    end
  end

  assign wr_ready  = (left == 3'd0);
  assign out_valid = (left != 3'd0);
  assign out_byte  = hold[8*ptr +: 8];

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  p_empty_word_r8: assert property (@(posedge clk) disable iff (rst)
    wr_fire && keep == 3'd0 |=> wr_ready && !out_valid);

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    wcount == '0 && !cfg_we |=> wcount == '0);

  p_cnt_dec_r4: assert property (@(posedge clk) disable iff (rst)
    wr_fire && wcount != '0 && !cfg_we |=> wcount == $past(wcount) - CNT_W'(1));

  p_start_clear_r3: assert property (@(posedge clk) disable iff (rst)
    wr_fire && wcount != '0 && !cfg_we |=> st_off == 2'd0);

  p_end_keep_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(end_off));

  p_rem_bound_r6: assert property (@(posedge clk) disable iff (rst)
    wr_fire && rem_small |=> {1'b0, left} <= 4'($past(rem)));
endmodule

// File: tb/word_byte_packer_tb.sv
`timescale 1ns/1ps
module word_byte_packer_tb;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [SW-1:0] pkt_len = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [31:0]   wr_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_byte;

  always #4 clk = ~clk;

  word_byte_packer #(.SIZE_W(SW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pkt_len(pkt_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int m_ord = 0, m_st = 0, m_en = 0, m_cnt = 0, m_rem = 0;
  bit m_junk = 0;
  int wseq = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic setup(input int o, input int s, input int e, input int c,
                       input int len, input bit junk);
    @(negedge clk);
    pkt_len   = SW'(len);
    cfg_wdata = {junk ? 7'h7f : 7'h00, o[0], junk ? 4'hf : 4'h0, s[1:0], e[1:0],
                 junk ? 2'b11 : 2'b00, c[13:0]};
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
    m_ord = o; m_st = s; m_en = e; m_cnt = c; m_rem = len; m_junk = junk;
  endtask

  task automatic send_word();
    logic [31:0] d;
    int lead, avail, n;
    string tag;
    wseq++;
    d = {8'(4*wseq), 8'(4*wseq+1), 8'(4*wseq+2), 8'(4*wseq+3)};
    lead  = (m_cnt != 0) ? m_st : 0;
    avail = 4 - lead;
    if (m_rem < 4) begin
      n = (m_rem < avail) ? m_rem : avail;
      tag = "R6";
    end else if (m_cnt == 0) begin
      n = 4 - m_en;
      tag = "R4 R5";
    end else begin
      n = avail;
      tag = (lead != 0) ? "R3" : "R2";
    end
    if (m_junk) tag = {tag, " R1"};
    chk(wr_ready === 1'b1, "R7", "wr_ready before word", wr_ready, 1);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      int idx;
      logic [7:0] exp;
      idx = lead + k;
      exp = (m_ord != 0) ? d[31-8*idx -: 8] : d[8*idx +: 8];
      if (((wseq + k) % 2) == 0) begin
        @(negedge clk);
        chk(out_valid === 1'b1 && out_byte === exp, "R7", "byte under backpressure",
            out_byte, exp);
      end
      out_ready = 1'b1;
      chk(out_valid === 1'b1 && out_byte === exp, tag, "byte value", out_byte, exp);
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(out_valid === 1'b0 && wr_ready === 1'b1, (n == 0) ? "R8" : "R7",
        "buffer empty after word", {out_valid, wr_ready}, 2'b01);
    m_rem = m_rem - n;
    if (m_cnt != 0) begin
      m_cnt = m_cnt - 1;
      m_st = 0;
    end
  endtask

  initial begin
    int lens[4];
    lens = '{200, 6, 3, 0};
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && wr_ready === 1'b1, "R9", "during reset", {out_valid, wr_ready}, 2'b01);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && wr_ready === 1'b1, "R9", "after reset", {out_valid, wr_ready}, 2'b01);
    send_word();
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 4; s++)
        for (int e = 0; e < 4; e++)
          for (int c = 0; c < 3; c++)
            for (int li = 0; li < 4; li++) begin
              setup(o, s, e, c, lens[li], ((s + e + c + li) % 2) == 1);
              for (int w = 0; w < c + 2; w++) send_word();
            end
    done = 1;
    summary();
    $finish;
  end
endmodule